// File: doc/BRIEF.md
# Two-Port Token Semaphore Bank

This block holds a small bank of hardware tokens that two independent ports use to claim exclusive use of a shared resource. The bank lives in its own address space: a port picks one token with the low bits of its address, and a write whose data bit 0 is 0 asks for the token while a write of 1 gives it back. A read tells the port whether it currently holds the token (0) or not (1), with that one bit copied onto every data line.

Each token keeps one request latch per port and an ownership state. When both ports want the same token, one wins and the other request stays latched; as soon as the holder gives the token back, the waiting port becomes the holder in the same update, with no retry needed. A request that arrives in the same clock cycle as the other port's request for a free token goes to a side fixed by a parameter. Read data is captured when a read begins and held until the read ends, so a port never sees the value change during one access.

Top module: `dual_token_bank`

## Requirements
- R1: A token is chosen by the low IDX_W address bits (IDX_W = log2 of NUM_TOKENS, 3 for 8 tokens); all higher address bits are ignored.
- R2: A write (sel=1, we=1) uses only data bit 0: 0 requests the token, 1 releases it; all other data bits are ignored.
- R3: A request to a free token makes the requester the holder from the next clock edge: the requester then reads 0 and the other port reads 1.
- R4: A request from the port that does not hold the token is latched and changes nothing visible while the holder keeps it; that port writing 1 before the release withdraws the request.
- R5: When the holder releases and the other port has a latched request, the other port becomes the holder at the same clock edge; with no latched request the token becomes free and both ports read 1.
- R6: Read data is the port's view bit replicated on all DATA_W lines: all zeros when the port holds the token, all ones otherwise.
- R7: A read (sel=1, oe=1, we=0) captures the view at the first clock edge where it is active and holds it unchanged until sel or oe goes low.
- R8: When both ports request the same free token, exactly one becomes holder: the one whose request came first, or on a same-cycle tie port A when TIE_TO_B=0 and port B when TIE_TO_B=1.
- R9: Reset (rstN low) puts every request latch in the released state and leaves every token free, so both ports read all ones.
- R10: Ownership changes only at an edge where at least one port writes, and never are both ports holders of the same token.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| aSel | input | 1 | Port A token-space select |
| aWe | input | 1 | Port A write enable |
| aOe | input | 1 | Port A output enable |
| aAddr | input | ADDR_W | Port A address; low IDX_W bits pick the token |
| aWdata | input | DATA_W | Port A write data; bit 0 is the request/release value |
| aRdata | output | DATA_W | Port A held read data |
| bSel | input | 1 | Port B token-space select |
| bWe | input | 1 | Port B write enable |
| bOe | input | 1 | Port B output enable |
| bAddr | input | ADDR_W | Port B address; low IDX_W bits pick the token |
| bWdata | input | DATA_W | Port B write data; bit 0 is the request/release value |
| bRdata | output | DATA_W | Port B held read data |

## Verification
The bench builds two copies of the block side by side on the same stimulus, both with eight tokens, a 13-bit address and 16-bit data, one with TIE_TO_B=0 and one with TIE_TO_B=1. Driving a same-cycle request from both ports into both copies makes each tie outcome observable at once, while every other scenario must give identical results on the two. The 13-bit address leaves ten unused upper bits, which lets the bench show that addresses differing only there reach the same token.

// File: rtl/token_bank_pkg.sv
package token_bank_pkg;

  // Strobes that one port's control hands to the shared datapath
  typedef struct packed {
    logic wr;      // write to the selected token this cycle
    logic bitVal;  // 0 = request, 1 = release
    logic rdLoad;  // first cycle of a read: capture the view
  } tokStb_t;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } owner_e;

endpackage

// File: rtl/token_bank_ctrl.sv
module token_bank_ctrl
  import token_bank_pkg::*;
#(
  parameter int unsigned IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sel,
  input  logic             we,
  input  logic             oe,
  input  logic [IDX_W-1:0] addrLo,
  input  logic             wBit,
  output tokStb_t          stb,
  output logic [IDX_W-1:0] idx
);

  logic rdAct;
  logic rdActQ;

  // A write takes precedence over output enable
  assign rdAct = sel && oe && !we;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdActQ <= 1'b0;
    else       rdActQ <= rdAct;
  end

  always_comb begin
    stb.wr     = sel && we;
    stb.bitVal = wBit;
    stb.rdLoad = rdAct && !rdActQ;
    idx        = addrLo;
  end

endmodule

// File: rtl/token_bank_core.sv
module token_bank_core
  import token_bank_pkg::*;
#(
  parameter int unsigned NUM_TOKENS = 8,
  parameter int unsigned IDX_W      = 3,
  parameter bit          TIE_TO_B   = 1'b0
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tokStb_t               stbA,
  input  logic [IDX_W-1:0]      idxA,
  input  tokStb_t               stbB,
  input  logic [IDX_W-1:0]      idxB,
  output logic                  rdBitA,
  output logic                  rdBitB,
  output logic [NUM_TOKENS-1:0] ownA,
  output logic [NUM_TOKENS-1:0] ownB
);

  localparam owner_e TIE_WINNER = TIE_TO_B ? OWN_B : OWN_A;

  for (genvar i = 0; i < NUM_TOKENS; i++) begin : g_tok
    logic   hitA, hitB;
    logic   reqAQ, reqBQ;       // 0 = request pending, 1 = released
    logic   reqANext, reqBNext;
    owner_e ownQ, ownNext;

    assign hitA = stbA.wr && (idxA == IDX_W'(i));
    assign hitB = stbB.wr && (idxB == IDX_W'(i));

    always_comb begin
      reqANext = hitA ? stbA.bitVal : reqAQ;
      reqBNext = hitB ? stbB.bitVal : reqBQ;
      ownNext  = ownQ;
      case (ownQ)
        OWN_A: if (reqANext) ownNext = reqBNext ? OWN_NONE : OWN_B;
        OWN_B: if (reqBNext) ownNext = reqANext ? OWN_NONE : OWN_A;
        default: begin
          if (!reqANext && !reqBNext) ownNext = TIE_WINNER;
          else if (!reqANext)         ownNext = OWN_A;
          else if (!reqBNext)         ownNext = OWN_B;
          else                        ownNext = OWN_NONE;
        end
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqAQ <= 1'b1;
        reqBQ <= 1'b1;
        ownQ  <= OWN_NONE;
      end else begin
        reqAQ <= reqANext;
        reqBQ <= reqBNext;
        ownQ  <= ownNext;
      end
    end

    assign ownA[i] = (ownQ == OWN_A);
    assign ownB[i] = (ownQ == OWN_B);
  end

  // Per-port view latches, loaded only when a read begins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBitA <= 1'b1;
      rdBitB <= 1'b1;
    end else begin
      if (stbA.rdLoad) rdBitA <= !ownA[idxA];
      if (stbB.rdLoad) rdBitB <= !ownB[idxB];
    end
  end

endmodule

// File: rtl/dual_token_bank.sv
module dual_token_bank
  import token_bank_pkg::*;
#(
  parameter int unsigned NUM_TOKENS = 8,
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned DATA_W     = 16,
  parameter bit          TIE_TO_B   = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              aSel,
  input  logic              aWe,
  input  logic              aOe,
  input  logic [ADDR_W-1:0] aAddr,
  input  logic [DATA_W-1:0] aWdata,
  output logic [DATA_W-1:0] aRdata,
  input  logic              bSel,
  input  logic              bWe,
  input  logic              bOe,
  input  logic [ADDR_W-1:0] bAddr,
  input  logic [DATA_W-1:0] bWdata,
  output logic [DATA_W-1:0] bRdata
);

  localparam int unsigned IDX_W = (NUM_TOKENS > 1) ? $clog2(NUM_TOKENS) : 1;

  tokStb_t               stbA, stbB;
  logic [IDX_W-1:0]      idxA, idxB;
  logic                  rdBitA, rdBitB;
  logic [NUM_TOKENS-1:0] ownAVec, ownBVec;
  logic                  unusedHi;

  assign unusedHi = ^{aAddr[ADDR_W-1:IDX_W], bAddr[ADDR_W-1:IDX_W],
                      aWdata[DATA_W-1:1], bWdata[DATA_W-1:1]};

  token_bank_ctrl #(.IDX_W(IDX_W)) u_ctrlA (
    .clk(clk), .rstN(rstN), .sel(aSel), .we(aWe), .oe(aOe),
    .addrLo(aAddr[IDX_W-1:0]), .wBit(aWdata[0]), .stb(stbA), .idx(idxA)
  );

  token_bank_ctrl #(.IDX_W(IDX_W)) u_ctrlB (
    .clk(clk), .rstN(rstN), .sel(bSel), .we(bWe), .oe(bOe),
    .addrLo(bAddr[IDX_W-1:0]), .wBit(bWdata[0]), .stb(stbB), .idx(idxB)
  );

  token_bank_core #(
    .NUM_TOKENS(NUM_TOKENS), .IDX_W(IDX_W), .TIE_TO_B(TIE_TO_B)
  ) u_core (
    .clk(clk), .rstN(rstN),
    .stbA(stbA), .idxA(idxA), .stbB(stbB), .idxB(idxB),
    .rdBitA(rdBitA), .rdBitB(rdBitB), .ownA(ownAVec), .ownB(ownBVec)
  );

  assign aRdata = {DATA_W{rdBitA}};
  assign bRdata = {DATA_W{rdBitB}};

endmodule

// File: rtl/token_bank_chk.sv
module token_bank_chk #(
  parameter int unsigned NUM_TOKENS = 8,
  parameter int unsigned DATA_W     = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  aSel,
  input logic                  aWe,
  input logic                  aOe,
  input logic                  bSel,
  input logic                  bWe,
  input logic                  bOe,
  input logic [DATA_W-1:0]     aRdata,
  input logic [DATA_W-1:0]     bRdata,
  input logic [NUM_TOKENS-1:0] ownA,
  input logic [NUM_TOKENS-1:0] ownB
);

  logic aRd, bRd, anyWr;
  assign aRd   = aSel && aOe && !aWe;
  assign bRd   = bSel && bOe && !bWe;
  assign anyWr = (aSel && aWe) || (bSel && bWe);

  // R10
  own_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ownA & ownB) == '0);

  // R10
  own_change_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ownA != $past(ownA)) || (ownB != $past(ownB))) |-> $past(anyWr));

  // R7
  a_read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(aRd) && $past(aRd, 2)) |-> $stable(aRdata));

  // R7
  b_read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(bRd) && $past(bRd, 2)) |-> $stable(bRdata));

  // R6
  a_rdata_uniform_chk: assert property (@(posedge clk) disable iff (!rstN)
    (aRdata == '0) || (aRdata == '1));

  // R6
  b_rdata_uniform_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bRdata == '0) || (bRdata == '1));

endmodule

bind dual_token_bank token_bank_chk #(
  .NUM_TOKENS(NUM_TOKENS), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rstN(rstN),
  .aSel(aSel), .aWe(aWe), .aOe(aOe),
  .bSel(bSel), .bWe(bWe), .bOe(bOe),
  .aRdata(aRdata), .bRdata(bRdata),
  .ownA(ownAVec), .ownB(ownBVec)
);

// File: tb/dual_token_bank_bench.sv
module dual_token_bank_bench;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int DW = 16;
  localparam logic [DW-1:0] ONES  = '1;
  localparam logic [DW-1:0] ZEROS = '0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aSel = 0, aWe = 0, aOe = 0, bSel = 0, bWe = 0, bOe = 0;
  logic [AW-1:0] aAddr = '0, bAddr = '0;
  logic [DW-1:0] aWdata = '0, bWdata = '0;
  logic [DW-1:0] aRdata, bRdata, aRdAlt, bRdAlt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_token_bank #(.NUM_TOKENS(8), .ADDR_W(AW), .DATA_W(DW), .TIE_TO_B(1'b0)) u_dual_token_bank (
    .clk(clk), .rstN(rstN),
    .aSel(aSel), .aWe(aWe), .aOe(aOe), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdata),
    .bSel(bSel), .bWe(bWe), .bOe(bOe), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdata)
  );

  dual_token_bank #(.NUM_TOKENS(8), .ADDR_W(AW), .DATA_W(DW), .TIE_TO_B(1'b1)) u_dual_token_bank_alt (
    .clk(clk), .rstN(rstN),
    .aSel(aSel), .aWe(aWe), .aOe(aOe), .aAddr(aAddr), .aWdata(aWdata), .aRdata(aRdAlt),
    .bSel(bSel), .bWe(bWe), .bOe(bOe), .bAddr(bAddr), .bWdata(bWdata), .bRdata(bRdAlt)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One-cycle write; starts and ends at a negedge
  task automatic wrTok(input bit side, input logic [AW-1:0] addr, input logic [DW-1:0] data);
    if (!side) begin aSel = 1; aWe = 1; aAddr = addr; aWdata = data; end
    else       begin bSel = 1; bWe = 1; bAddr = addr; bWdata = data; end
    @(negedge clk);
    aSel = 0; aWe = 0; bSel = 0; bWe = 0;
  endtask

  // One-cycle read from a given port; samples both copies
  task automatic rdTok(input bit side, input logic [AW-1:0] addr,
                       output logic [DW-1:0] v, output logic [DW-1:0] vAlt);
    if (!side) begin aSel = 1; aOe = 1; aAddr = addr; end
    else       begin bSel = 1; bOe = 1; bAddr = addr; end
    @(negedge clk);
    v    = side ? bRdata : aRdata;
    vAlt = side ? bRdAlt : aRdAlt;
    aSel = 0; aOe = 0; bSel = 0; bOe = 0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DW-1:0] v, va;
    for (int i = 0; i < 8; i++) begin
      rdTok(0, AW'(i), v, va); chk("R9 port A free after reset", v, ONES);
      rdTok(1, AW'(i), v, va); chk("R9 port B free after reset", v, ONES);
    end
  endtask

  task automatic t_claim();
    logic [DW-1:0] v, va;
    wrTok(0, 13'd2, 16'h0000);
    rdTok(0, 13'd2, v, va); chk("R3 requester reads zeros (R6)", v, ZEROS);
    rdTok(1, 13'd2, v, va); chk("R3 other port reads ones (R6)", v, ONES);
  endtask

  task automatic t_queue();
    logic [DW-1:0] v, va;
    wrTok(1, 13'd2, 16'h0000);
    rdTok(1, 13'd2, v, va); chk("R4 pending port still reads ones", v, ONES);
    rdTok(0, 13'd2, v, va); chk("R4 holder unaffected", v, ZEROS);
    wrTok(0, 13'd2, 16'h0001);
    rdTok(1, 13'd2, v, va); chk("R5 pending port takes token", v, ZEROS);
    rdTok(0, 13'd2, v, va); chk("R5 old holder reads ones", v, ONES);
    wrTok(1, 13'd2, 16'h0001);
    rdTok(0, 13'd2, v, va); chk("R5 free after release A", v, ONES);
    rdTok(1, 13'd2, v, va); chk("R5 free after release B", v, ONES);
  endtask

  task automatic t_withdraw();
    logic [DW-1:0] v, va;
    wrTok(0, 13'd5, 16'h0000);
    wrTok(1, 13'd5, 16'h0000);
    wrTok(1, 13'd5, 16'h0001);
    wrTok(0, 13'd5, 16'h0001);
    rdTok(1, 13'd5, v, va); chk("R4 withdrawn request not granted", v, ONES);
    rdTok(0, 13'd5, v, va); chk("R4 token free after withdraw", v, ONES);
  endtask

  task automatic t_fields();
    logic [DW-1:0] v, va;
    // high address bits set, upper data bits set, bit 0 = 0 -> request token 3
    wrTok(0, 13'h1F03, 16'hFFFE);
    rdTok(0, 13'd3, v, va); chk("R1 high address bits ignored", v, ZEROS);
    rdTok(1, 13'h0AB3, v, va); chk("R1 other port same token", v, ONES);
    // upper data bits clear, bit 0 = 1 -> release
    wrTok(0, 13'h0403, 16'h0001);
    rdTok(0, 13'd3, v, va); chk("R2 only data bit 0 used", v, ONES);
    rdTok(0, 13'd4, v, va); chk("R1 neighbour token untouched", v, ONES);
  endtask

  task automatic t_tie();
    logic [DW-1:0] v, va;
    aSel = 1; aWe = 1; aAddr = 13'd6; aWdata = 16'h0000;
    bSel = 1; bWe = 1; bAddr = 13'd6; bWdata = 16'h0000;
    @(negedge clk);
    aSel = 0; aWe = 0; bSel = 0; bWe = 0;
    rdTok(0, 13'd6, v, va);
    chk("R8 tie default copy: A wins", v, ZEROS);
    chk("R8 tie alt copy: A loses", va, ONES);
    rdTok(1, 13'd6, v, va);
    chk("R8 tie default copy: B loses", v, ONES);
    chk("R8 tie alt copy: B wins", va, ZEROS);
    wrTok(0, 13'd6, 16'h0001);
    wrTok(1, 13'd6, 16'h0001);
    rdTok(0, 13'd6, v, va); chk("R5 tie token freed", v, ONES);
  endtask

  task automatic t_earlier();
    logic [DW-1:0] v, va;
    wrTok(1, 13'd7, 16'h0000);
    wrTok(0, 13'd7, 16'h0000);
    rdTok(1, 13'd7, v, va);
    chk("R8 earlier requester B wins", v, ZEROS);
    chk("R8 earlier requester B wins alt copy", va, ZEROS);
    wrTok(0, 13'd7, 16'h0001);
    wrTok(1, 13'd7, 16'h0001);
  endtask

  task automatic t_hold();
    logic [DW-1:0] v, va;
    wrTok(0, 13'd1, 16'h0000);
    wrTok(1, 13'd1, 16'h0000);
    // B starts a held read while A holds the token
    bSel = 1; bOe = 1; bAddr = 13'd1;
    @(negedge clk);
    chk("R7 held read initial view", bRdata, ONES);
    aSel = 1; aWe = 1; aAddr = 13'd1; aWdata = 16'h0001;
    @(negedge clk);
    aSel = 0; aWe = 0;
    chk("R7 view frozen during read", bRdata, ONES);
    @(negedge clk);
    chk("R7 view still frozen", bRdata, ONES);
    bSel = 0; bOe = 0;
    @(negedge clk);
    rdTok(1, 13'd1, v, va); chk("R7 new read sees handover", v, ZEROS);
    wrTok(1, 13'd1, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 A data during reset", aRdata, ONES);
    chk("R9 B data during reset", bRdata, ONES);
    rstN = 1;
    @(negedge clk);
    t_reset();
    t_claim();
    t_queue();
    t_withdraw();
    t_fields();
    t_tie();
    t_earlier();
    t_hold();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule